// File: doc/BRIEF.md
# Reset and Power-Mode Controller

This block decides which operating state a processor core is in: held in reset, waiting for the reset exception to be taken, executing, sleeping, or in standby. It watches an external active-low reset pin, the level of the non-maskable interrupt pin, a single-cycle pulse that marks execution of the sleep instruction, a standby-select control bit, a combined wake request (an enabled interrupt or an NMI request), and an acknowledge from the exception sequencer. From these it drives a CPU halt, separate clock enables for the CPU and for the on-chip peripherals, and reset strobes for the core domain and for a set of retained system domains.

The level of the NMI pin during reset chooses the kind of reset. With NMI high, the reset is a power-on reset: at release, the core domain and every retained domain are cleared. With NMI low, the reset is a manual reset: only the core domain, which includes the peripheral registers, is cleared. The retained domains (bus-state, break, system control and pin function) keep their contents, so external memory refresh is not disturbed. The kind of the last reset is held on a status output.

Top module: `opstate_ctrl`

## Requirements
- R1: While `ext_reset_n` is sampled low, the following cycle shows `cpu_halt`=1, `exc_req`=0, `cpu_clk_en`=1, `per_clk_en`=1, `core_rst`=0 and every bit of `ret_rst`=0.
- R2: `rst_por` equals the `nmi_lvl` level sampled at the last clock edge at which `ext_reset_n` was low (1 = power-on, 0 = manual). It holds that value until the next reset.
- R3: After the first edge that samples `ext_reset_n` high following a reset, `core_rst` is 1 for exactly one cycle.
- R4: In that same cycle every bit of `ret_rst` is 1 when `rst_por`=1. After a manual reset, `ret_rst` stays 0.
- R5: From release until an edge samples `exc_ack`=1, `exc_req`=1 and `cpu_halt`=1. The cycle after that edge shows `exc_req`=0 and `cpu_halt`=0 (run state, both clock enables 1).
- R6: In the run state, `sleep_pulse`=1 with `standby_sel`=0 enters sleep in the next cycle: `cpu_halt`=1, `cpu_clk_en`=0, `per_clk_en`=1.
- R7: In sleep, `wake_irq` sampled high at edge k returns the block to the run state after edge k+1 (`cpu_halt`=0, `cpu_clk_en`=1), within two cycles.
- R8: In the run state, `sleep_pulse`=1 with `standby_sel`=1 enters standby in the next cycle: `cpu_halt`=1, `cpu_clk_en`=0, `per_clk_en`=0.
- R9: Standby is left only through reset. `wake_irq` and `sleep_pulse` have no effect on the outputs in standby.
- R10: `sleep_pulse` has no effect outside the run state (while waiting for `exc_ack`, or in sleep).
- R11: Reset asserted in any state, standby and sleep included, gives the R1 outputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_reset_n | input | 1 | External reset pin, active low, sampled synchronously |
| nmi_lvl | input | 1 | NMI pin level, picks the reset kind |
| sleep_pulse | input | 1 | One-cycle pulse when the sleep instruction executes |
| standby_sel | input | 1 | 1 selects standby, 0 selects sleep |
| wake_irq | input | 1 | Enabled interrupt or NMI request |
| exc_ack | input | 1 | Exception sequencer has taken the reset exception |
| cpu_halt | output | 1 | CPU must not execute |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| exc_req | output | 1 | Request to start reset exception processing |
| core_rst | output | 1 | One-cycle reset strobe for the core and peripheral domain |
| ret_rst | output | RET_DOMAINS | One-cycle reset strobes for the retained domains |
| rst_por | output | 1 | Kind of the last reset, 1 = power-on |

## Verification
The embedded assertions check the following on every cycle out of reset. The core strobe never lasts two cycles. A retained-domain strobe appears only together with the core strobe after a power-on reset. The reset kind stays stable. Standby implies both clocks off, and standby is never left without reset. A registered wake in sleep always reaches the run state, and the halt holds while the exception request is unacknowledged. The bench scenarios cover the rest. They show the outputs while the pin is held low from every state and the kind taken from the last low cycle. They also give the exact two-cycle wake latency and show that sleep pulses and wakes are ignored in the states where they must do nothing.

// File: rtl/opstate_pkg.sv
package opstate_pkg;
   typedef enum logic [2:0] {
      OS_RESET = 3'd0,
      OS_INIT  = 3'd1,
      OS_RUN   = 3'd2,
      OS_SLEEP = 3'd3,
      OS_STBY  = 3'd4
   } opstate_e;
endpackage

// File: rtl/wake_stage.sv
module wake_stage #(
   parameter int WAKE_REG = 1
) (
   input  logic clk,
   input  logic ext_reset_n,
   input  logic wake_irq,
   output logic wake_ev
);
   if (WAKE_REG != 0 && WAKE_REG != 1) begin : g_bad_wake
      $error("WAKE_REG must be 0 or 1");
   end

   if (WAKE_REG == 1) begin : g_reg
      logic wq;
      always_ff @(posedge clk) begin
         if (!ext_reset_n) wq <= 1'b0;
         else              wq <= wake_irq;
      end
      assign wake_ev = wq;
   end else begin : g_direct
      assign wake_ev = wake_irq;
   end
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
   import opstate_pkg::*;
#(
   parameter int STBY_EN = 1
) (
   input  logic     clk,
   input  logic     ext_reset_n,
   input  logic     sleep_pulse,
   input  logic     standby_sel,
   input  logic     wake_ev,
   input  logic     exc_ack,
   output opstate_e st
);
   if (STBY_EN != 0 && STBY_EN != 1) begin : g_bad_stby
      $error("STBY_EN must be 0 or 1");
   end

   logic go_stby;
   if (STBY_EN == 1) begin : g_stby
      assign go_stby = standby_sel;
   end else begin : g_nostby
      assign go_stby = 1'b0;
   end

   opstate_e st_nx;
   always_comb begin
      st_nx = st;
      unique case (st)
         OS_RESET: st_nx = OS_INIT;
         OS_INIT:  if (exc_ack) st_nx = OS_RUN;
         OS_RUN:   if (sleep_pulse) st_nx = go_stby ? OS_STBY : OS_SLEEP;
         OS_SLEEP: if (wake_ev) st_nx = OS_RUN;
         OS_STBY:  st_nx = OS_STBY;
         default:  st_nx = OS_RESET;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!ext_reset_n) st <= OS_RESET;
      else              st <= st_nx;
   end

   AST_STBY_STICKY: assert property (@(posedge clk) disable iff (!ext_reset_n)
      (st == OS_STBY) |=> (st == OS_STBY)); // R9
   AST_WAKE_RUN: assert property (@(posedge clk) disable iff (!ext_reset_n)
      (st == OS_SLEEP && wake_ev) |=> (st == OS_RUN)); // R7
   AST_SLEEP_ONLY_RUN: assert property (@(posedge clk) disable iff (!ext_reset_n)
      (st == OS_INIT && !exc_ack) |=> (st == OS_INIT)); // R10
endmodule

// File: rtl/rst_capture.sv
module rst_capture #(
   parameter int RET_DOMAINS = 4
) (
   input  logic                   clk,
   input  logic                   ext_reset_n,
   input  logic                   nmi_lvl,
   input  logic                   in_rst_st,
   output logic                   por_q,
   output logic                   core_q,
   output logic [RET_DOMAINS-1:0] ret_q
);
   if (RET_DOMAINS < 1 || RET_DOMAINS > 16) begin : g_bad_ret
      $error("RET_DOMAINS must be 1..16");
   end

   always_ff @(posedge clk) begin
      if (!ext_reset_n) por_q <= nmi_lvl;
   end

   always_ff @(posedge clk) begin
      if (!ext_reset_n) begin
         core_q <= 1'b0;
         ret_q  <= '0;
      end else begin
         core_q <= in_rst_st;
         ret_q  <= {RET_DOMAINS{in_rst_st & por_q}};
      end
   end

   AST_POR_HELD: assert property (@(posedge clk) disable iff (!ext_reset_n)
      1'b1 |=> $stable(por_q)); // R2
   AST_CORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!ext_reset_n)
      core_q |=> !core_q); // R3
endmodule

// File: rtl/opstate_ctrl.sv
module opstate_ctrl
   import opstate_pkg::*;
#(
   parameter int RET_DOMAINS = 4,
   parameter int WAKE_REG    = 1,
   parameter int STBY_EN     = 1
) (
   input  logic                   clk,
   input  logic                   ext_reset_n,
   input  logic                   nmi_lvl,
   input  logic                   sleep_pulse,
   input  logic                   standby_sel,
   input  logic                   wake_irq,
   input  logic                   exc_ack,
   output logic                   cpu_halt,
   output logic                   cpu_clk_en,
   output logic                   per_clk_en,
   output logic                   exc_req,
   output logic                   core_rst,
   output logic [RET_DOMAINS-1:0] ret_rst,
   output logic                   rst_por
);
   opstate_e st;
   logic     wake_ev;

   wake_stage #(.WAKE_REG(WAKE_REG)) u_wake (
      .clk(clk), .ext_reset_n(ext_reset_n), .wake_irq(wake_irq), .wake_ev(wake_ev)
   );

   mode_fsm #(.STBY_EN(STBY_EN)) u_fsm (
      .clk(clk), .ext_reset_n(ext_reset_n), .sleep_pulse(sleep_pulse),
      .standby_sel(standby_sel), .wake_ev(wake_ev), .exc_ack(exc_ack), .st(st)
   );

   rst_capture #(.RET_DOMAINS(RET_DOMAINS)) u_cap (
      .clk(clk), .ext_reset_n(ext_reset_n), .nmi_lvl(nmi_lvl),
      .in_rst_st(st == OS_RESET), .por_q(rst_por), .core_q(core_rst), .ret_q(ret_rst)
   );

   always_comb begin
      cpu_halt   = (st != OS_RUN);
      cpu_clk_en = !(st == OS_SLEEP || st == OS_STBY);
      per_clk_en = (st != OS_STBY);
      exc_req    = (st == OS_INIT);
   end

   AST_RET_ONLY_POR: assert property (@(posedge clk) disable iff (!ext_reset_n)
      (|ret_rst) |-> (rst_por && core_rst)); // R4
   AST_STROBE_WITH_REQ: assert property (@(posedge clk) disable iff (!ext_reset_n)
      core_rst |-> (exc_req && cpu_halt)); // R3
   AST_HALT_UNTIL_ACK: assert property (@(posedge clk) disable iff (!ext_reset_n)
      (exc_req && !exc_ack) |=> (exc_req && cpu_halt)); // R5
   AST_STBY_CLOCKS: assert property (@(posedge clk) disable iff (!ext_reset_n)
      !per_clk_en |-> (!cpu_clk_en && cpu_halt)); // R8
endmodule

// File: tb/sim_opstate_ctrl.sv
`timescale 1ns/1ps
module sim_opstate_ctrl;
   localparam int RD = 4;
   localparam int S_RST = 0, S_INIT = 1, S_RUN = 2, S_SLP = 3, S_STB = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic ext_reset_n = 1'b0, nmi_lvl = 1'b1, sleep_pulse = 1'b0;
   logic standby_sel = 1'b0, wake_irq = 1'b0, exc_ack = 1'b0;
   logic cpu_halt, cpu_clk_en, per_clk_en, exc_req, core_rst, rst_por;
   logic [RD-1:0] ret_rst;

   opstate_ctrl #(.RET_DOMAINS(RD)) u0 (
      .clk(clk), .ext_reset_n(ext_reset_n), .nmi_lvl(nmi_lvl), .sleep_pulse(sleep_pulse),
      .standby_sel(standby_sel), .wake_irq(wake_irq), .exc_ack(exc_ack),
      .cpu_halt(cpu_halt), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
      .exc_req(exc_req), .core_rst(core_rst), .ret_rst(ret_rst), .rst_por(rst_por)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   int m_st = S_RST;
   logic m_por = 1'b0, m_core = 1'b0, m_ret = 1'b0, m_wq = 1'b0;

   function automatic logic e_halt(int s);  return s != S_RUN; endfunction
   function automatic logic e_cclk(int s);  return !(s == S_SLP || s == S_STB); endfunction
   function automatic logic e_pclk(int s);  return s != S_STB; endfunction
   function automatic logic e_req(int s);   return s == S_INIT; endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic string tag_of(int s);
      case (s)
         S_RST:  return "R1";
         S_INIT: return "R5";
         S_SLP:  return "R6";
         S_STB:  return "R8";
         default: return "R5";
      endcase
   endfunction

   task automatic step(logic r_n, logic n, logic sp, logic sb, logic w, logic a);
      int nx;
      ext_reset_n = r_n; nmi_lvl = n; sleep_pulse = sp;
      standby_sel = sb; wake_irq = w; exc_ack = a;
      @(posedge clk);
      if (!r_n) begin
         m_st = S_RST; m_por = n; m_core = 1'b0; m_ret = 1'b0; m_wq = 1'b0;
      end else begin
         nx = m_st;
         case (m_st)
            S_RST:  nx = S_INIT;
            S_INIT: if (a) nx = S_RUN;
            S_RUN:  if (sp) nx = sb ? S_STB : S_SLP;
            S_SLP:  if (m_wq) nx = S_RUN;
            default: nx = m_st;
         endcase
         m_core = (m_st == S_RST);
         m_ret  = (m_st == S_RST) && m_por;
         m_wq   = w;
         m_st   = nx;
      end
      @(negedge clk);
      chk(tag_of(m_st), "cpu_halt", cpu_halt, e_halt(m_st));
      chk(tag_of(m_st), "cpu_clk_en", cpu_clk_en, e_cclk(m_st));
      chk(tag_of(m_st), "per_clk_en", per_clk_en, e_pclk(m_st));
      chk(tag_of(m_st), "exc_req", exc_req, e_req(m_st));
      chk("R3", "core_rst", core_rst, m_core);
      chk("R4", "ret_rst", ret_rst, {RD{m_ret}});
      if (m_st != S_RST || !r_n) chk("R2", "rst_por", rst_por, m_por);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd7331);
      @(negedge clk);
      // R1 R11: power-on reset, NMI high
      repeat (3) step(0, 1, 0, 0, 0, 0);
      chk("R1", "halt in reset", cpu_halt, 1);
      chk("R1", "core_rst in reset", core_rst, 0);
      // R3 R4 R2: release
      step(1, 0, 0, 0, 0, 0);
      chk("R3", "core strobe", core_rst, 1);
      chk("R4", "ret strobe por", ret_rst, {RD{1'b1}});
      chk("R2", "por kind", rst_por, 1);
      // R10: sleep pulse while waiting for ack is ignored
      step(1, 0, 1, 0, 0, 0);
      chk("R3", "strobe ends", core_rst, 0);
      chk("R10", "sleep ignored in init", exc_req, 1);
      step(1, 0, 0, 0, 0, 1);
      chk("R5", "run after ack", cpu_halt, 0);
      // R6 sleep
      step(1, 0, 1, 0, 0, 0);
      chk("R6", "sleep cpu clk", cpu_clk_en, 0);
      chk("R6", "sleep per clk", per_clk_en, 1);
      step(1, 0, 1, 0, 0, 0);
      chk("R10", "sleep pulse in sleep", cpu_halt, 1);
      // R7 wake latency
      step(1, 0, 0, 0, 1, 0);
      chk("R7", "still halted one edge", cpu_halt, 1);
      step(1, 0, 0, 0, 0, 0);
      chk("R7", "run after two edges", cpu_halt, 0);
      // R8 R9 standby
      step(1, 0, 1, 1, 0, 0);
      chk("R8", "standby per clk", per_clk_en, 0);
      repeat (4) step(1, 0, 1, 1, 1, 1);
      chk("R9", "standby kept", per_clk_en, 0);
      chk("R9", "standby halt", cpu_halt, 1);
      // R11 R2 R4: manual reset from standby, NMI low
      step(0, 1, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
      chk("R11", "reset from standby", per_clk_en, 1);
      step(1, 1, 0, 0, 0, 0);
      chk("R2", "manual kind", rst_por, 0);
      chk("R4", "no ret strobe manual", ret_rst, '0);
      chk("R3", "core strobe manual", core_rst, 1);
      // random traffic
      for (int i = 0; i < 4000; i++) begin
         logic r_n, sp, sb, w, a, n;
         r_n = ($urandom_range(0, 99) >= 3);
         n   = 1'($urandom_range(0, 1));
         sp  = ($urandom_range(0, 9) == 0);
         sb  = ($urandom_range(0, 3) == 0);
         w   = ($urandom_range(0, 5) == 0);
         a   = ($urandom_range(0, 2) == 0);
         step(r_n, n, sp, sb, w, a);
      end
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule